// File: doc/BRIEF.md
# Card Bus Cycle Phase Sequencer

This block sets the timing of a single memory or I/O access toward a removable card. Each access runs three phases in a fixed order: setup, command and recovery. The command strobe is active (low) only during the command phase. The length of each phase is counted in internal clock ticks, which arrive on a clock-enable input. An external clock source produces these ticks; this block does not derive them.

Each phase length comes from an 8-bit timing register. The register holds a multiplier and a coarse prescale code, and the phase lasts prescale × multiplier + 1 ticks. Two sets of three registers are kept. A select input, sampled when the access starts, chooses the set that governs the whole access. All register values the access needs are captured at the start. A write made while an access is running therefore changes only later accesses.

A busy output covers the whole access. A one-clock done pulse marks its end. A start request made while busy has no effect.

Top module: `card_cycle_timer`

## Requirements
- R1: After reset, `cmd_n` is 1 and `busy` and `done` are 0. Both sets hold setup 8'h01, command 8'h06 and recovery 8'h03, so a default access lasts 2, 7 and 4 ticks.
- R2: An access runs setup, then command, then recovery. `cmd_n` is 0 in exactly the command-phase cycles. `busy` is 1 through all three phases.
- R3: Bits [5:0] of a timing register hold the multiplier M. Bits [7:6] hold a code selecting the prescale factor P: 0→1, 1→16, 2→64, 3→256. The phase lasts P×M+1 ticks, so M=0 gives 1 tick.
- R4: Register indexes are fixed. Set 0 uses setup 8'h3A, command 8'h3B and recovery 8'h3C. Set 1 uses 8'h3D, 8'h3E and 8'h3F. A write to any other index changes no register.
- R5: `set_sel` is sampled on the edge that accepts `start`. That set's registers govern all three phases of the access.
- R6: `start` while `busy` is 1 is ignored. It neither restarts nor lengthens the access, it does not change the set in use, and it does not cause a second access.
- R7: `done` is 1 for exactly one clock. It rises on the edge where `busy` falls.
- R8: A write made during an access, or on the same edge that accepts `start`, does not change that access. It does govern the next access.
- R9: Phase counters advance only on edges where `tick` is 1. While `tick` is 0, the phase and `cmd_n` hold.
- R10: `start` is accepted on any clock edge while idle, whatever the value of `tick`. The first setup tick is counted from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal clock enable; one phase tick per high cycle |
| start | input | 1 | Access start request |
| set_sel | input | 1 | Timer set used by the access being started |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index for the write |
| wr_data | input | 8 | Register write data: {code[1:0], mult[5:0]} |
| cmd_n | output | 1 | Command strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The bench builds the block with its default parameters: two timer sets, a 6-bit multiplier and base index 8'h3A. With these values every prescale code can be exercised with small multipliers. The longest phase tested is 321 ticks, so all four codes and the M=0 single-tick case run in a short simulation. Each access is measured by counting the cycles spent in each phase at the ports. The bench also drives writes and stray start requests mid-access, and holds `tick` low during the setup phase.

// File: rtl/card_cycle_timer.sv
module card_cycle_timer #(
  parameter int          NUM_SETS  = 2,
  parameter int          MULT_W    = 6,
  parameter int          IDX_W     = 8,
  parameter logic [7:0]  BASE_IDX  = 8'h3A,
  parameter logic [7:0]  DEF_SETUP = 8'h01,
  parameter logic [7:0]  DEF_CMD   = 8'h06,
  parameter logic [7:0]  DEF_REC   = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             set_sel,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic             cmd_n,
  output logic             busy,
  output logic             done
);
  localparam int REG_W   = MULT_W + 2;
  localparam int MAX_LEN = 256 * ((1 << MULT_W) - 1) + 1;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_CMD, S_REC} phase_t;

  phase_t               phase;
  logic [CNT_W-1:0]     cnt;
  logic [REG_W-1:0]     cap_cmd, cap_rec;
  logic [REG_W-1:0]     tregs [NUM_SETS][3];
  logic                 last_tick;

  function automatic logic [CNT_W-1:0] plen(input logic [REG_W-1:0] r);
    int f;
    case (r[REG_W-1:REG_W-2])
      2'd0:    f = 1;
      2'd1:    f = 16;
      2'd2:    f = 64;
      default: f = 256;
    endcase
    return CNT_W'(f * int'(r[MULT_W-1:0]) + 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        tregs[s][0] <= REG_W'(DEF_SETUP);
        tregs[s][1] <= REG_W'(DEF_CMD);
        tregs[s][2] <= REG_W'(DEF_REC);
      end
    end else if (wr_en) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int p = 0; p < 3; p++)
          if (wr_idx == IDX_W'(int'(BASE_IDX) + 3 * s + p))
            tregs[s][p] <= REG_W'(wr_data);
    end
  end

  assign last_tick = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      cnt     <= '0;
      cap_cmd <= '0;
      cap_rec <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        S_IDLE: if (start) begin
          phase   <= S_SETUP;
          cnt     <= plen(tregs[set_sel][0]);
          cap_cmd <= tregs[set_sel][1];
          cap_rec <= tregs[set_sel][2];
        end
        S_SETUP: if (last_tick) begin
          phase <= S_CMD;
          cnt   <= plen(cap_cmd);
        end else if (tick) cnt <= cnt - 1'b1;
        S_CMD: if (last_tick) begin
          phase <= S_REC;
          cnt   <= plen(cap_rec);
        end else if (tick) cnt <= cnt - 1'b1;
        default: if (last_tick) begin
          phase <= S_IDLE;
          done  <= 1'b1;
        end else if (tick) cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy  = (phase != S_IDLE);
  assign cmd_n = (phase != S_CMD);

  // R2
  strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_n |-> busy);

  // R2
  strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_n) |-> $past(busy));

  // R7
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  begin_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(cmd_n) && $stable(cnt)));

  // R6
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_tick) |=> (busy && $stable(cap_cmd) && $stable(cap_rec)));
endmodule

// File: tb/card_cycle_timer_tb.sv
module card_cycle_timer_tb;
  logic       clk = 0, rst_n = 0, tick = 1, start = 0, set_sel = 0, wr_en = 0;
  logic [7:0] wr_idx = 0, wr_data = 0;
  logic       cmd_n, busy, done;
  int checks = 0, errors = 0;

  card_cycle_timer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .set_sel(set_sel), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cmd_n(cmd_n), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // do_st: drive start here; ex_at: iteration for a stray start; wr_at: iteration for a write
  task automatic run(input bit do_st, input bit sel, input int ex_at, input int wr_at,
                     input logic [7:0] widx, input logic [7:0] wdat,
                     output int s, output int c, output int r);
    bit seen = 0;
    int n = 0;
    s = 0; c = 0; r = 0;
    if (do_st) begin
      @(negedge clk); start = 1; set_sel = sel;
      @(negedge clk); start = 0;
    end
    while (busy && n < 5000) begin
      start = (n == ex_at); set_sel = (n == ex_at) ? ~sel : sel;
      wr_en = (n == wr_at); wr_idx = widx; wr_data = wdat;
      if (!cmd_n) begin c++; seen = 1; end
      else if (!seen) s++;
      else r++;
      @(negedge clk); n++;
    end
    start = 0; wr_en = 0;
    chk(done, 1, "R7 done at end");
    @(negedge clk);
    chk(done, 0, "R7 done one clock");
    chk(busy, 0, "R6 no second access");
  endtask

  task automatic expect3(input bit sel, input int es, input int ec, input int er, input string tag);
    int s, c, r;
    run(1, sel, -1, -1, 8'h00, 8'h00, s, c, r);
    chk(s, es, {tag, " setup"}); chk(c, ec, {tag, " cmd"}); chk(r, er, {tag, " rec"});
  endtask

  task automatic t_reset;
    chk(cmd_n, 1, "R1 cmd_n"); chk(busy, 0, "R1 busy"); chk(done, 0, "R1 done");
    expect3(0, 2, 7, 4, "R1 R2 set0 default");
    expect3(1, 2, 7, 4, "R1 R5 set1 default");
  endtask

  task automatic t_codes;
    wr(8'h3D, 8'h42); wr(8'h3E, 8'h00); wr(8'h3F, 8'hC1);
    expect3(1, 33, 1, 257, "R3 R4 R5 set1 codes");
    expect3(0, 2, 7, 4, "R4 R5 set0 untouched");
  endtask

  task automatic t_bad_idx;
    wr(8'h40, 8'hFF); wr(8'h39, 8'hFF);
    expect3(0, 2, 7, 4, "R4 set0 after stray idx");
    expect3(1, 33, 1, 257, "R4 set1 after stray idx");
  endtask

  task automatic t_busy_start;
    int s, c, r;
    run(1, 0, 3, -1, 8'h00, 8'h00, s, c, r);
    chk(s, 2, "R6 setup"); chk(c, 7, "R6 cmd"); chk(r, 4, "R6 rec");
  endtask

  task automatic t_mid_write;
    int s, c, r;
    run(1, 0, -1, 1, 8'h3B, 8'h0A, s, c, r);
    chk(c, 7, "R8 current cmd kept");
    expect3(0, 2, 11, 4, "R8 next uses write");
  endtask

  task automatic t_same_edge;
    int s, c, r;
    @(negedge clk); start = 1; set_sel = 0; wr_en = 1; wr_idx = 8'h3C; wr_data = 8'h85;
    @(negedge clk); start = 0; wr_en = 0;
    run(0, 0, -1, -1, 8'h00, 8'h00, s, c, r);
    chk(r, 4, "R8 same-edge write ignored");
    expect3(0, 2, 11, 321, "R3 R8 code2 next access");
  endtask

  task automatic t_freeze;
    int s, c, r;
    @(negedge clk); tick = 0; start = 1; set_sel = 0;
    @(negedge clk); start = 0;
    chk(busy, 1, "R10 start without tick");
    for (int i = 0; i < 10; i++) begin
      if (!(busy && cmd_n)) chk(0, 1, "R9 hold in setup");
      @(negedge clk);
    end
    chk(busy && cmd_n, 1, "R9 still setup");
    tick = 1;
    run(0, 0, -1, -1, 8'h00, 8'h00, s, c, r);
    chk(s, 2, "R9 setup after hold"); chk(c, 11, "R9 cmd"); chk(r, 321, "R9 rec");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_codes;
    t_bad_idx;
    t_busy_start;
    t_mid_write;
    t_same_edge;
    t_freeze;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule